// File: doc/BRIEF.md
# Mirrored Memory-Mapped Byte Port Decoder

This block sits on a host CPU's memory bus and presents two byte-wide output latches and two byte-wide input ports as memory locations. Any memory access whose top three address bits are `001` (2000h through 3FFFh) lands in the I/O window. The decode inside the window looks only at address bit 0. Every even address in the window reaches port 0 and every odd address reaches port 1, so the two ports are repeated across the whole 8K range. Software can therefore use any convenient address, or step through the window, and alternate between the two ports.

A write in the window loads the addressed output latch on the next clock edge. The latch then holds that byte until another write reaches it. A read in the window drives the addressed input byte onto the data bus and raises the output enable. The block also raises a ROM chip-select override whenever address bit 13 is high, so the ROM image that would otherwise echo into this range stays quiet.

The bus is a plain strobe bus and not a stream. It has no valid/ready pair and no back-pressure. Every access completes in the cycle it is presented.

Top module: `mmio_mirror_ports`

## Requirements
- R1: While `rst_n` is low, both output latches (`port_q0`, `port_q1`) read 00h.
- R2: An access is in the window exactly when `addr[15:13]` equals `001`. For any other address, `dout_oe` stays low, `dout` reads 00h and neither latch changes.
- R3: `addr[0]` selects the port. A value of 0 selects port 0 (`port_q0` / `port_in0`) and a value of 1 selects port 1 (`port_q1` / `port_in1`).
- R4: The ports are mirrored. Every even address in the window, for example 9990 decimal, reaches port 0. Every odd address in the window, for example 9999 decimal, reaches port 1.
- R5: When `mreq_n` and `wr_n` are both low and the address is in the window, the selected latch takes `din` at the next rising clock edge. The new value appears on the latch output right after that edge.
- R6: A latch keeps its value in every cycle in which no in-window write selects it. This covers cycles where `mreq_n` or `wr_n` is high, writes to the other port, and reads.
- R7: `dout_oe` is high only while `mreq_n` and `rd_n` are both low and the address is in the window. In that case `dout` combinationally equals the selected input port. Otherwise `dout` is 00h.
- R8: `rom_cs_block` combinationally equals `addr[13]`, whatever the state of the bus strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; latch writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Bus address |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU, 00h when not enabled |
| dout_oe | output | 1 | High while the block drives read data |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| port_in0 | input | 8 | Input port 0 (even addresses) |
| port_in1 | input | 8 | Input port 1 (odd addresses) |
| port_q0 | output | 8 | Output latch 0 (even addresses) |
| port_q1 | output | 8 | Output latch 1 (odd addresses) |
| rom_cs_block | output | 1 | ROM chip-select override, high when addr[13] is high |

## Verification
The read path and the ROM override are swept over all 65536 addresses. The input-port bytes change with the address on each step, so a wrong parity choice shows up as a wrong byte, and an edge error in the window shows up as a stray or missing enable. Writes step through the whole address space with a stride of 97, which hits both parities in and out of the window. On each step the strobe mix rotates through a full write, write with `mreq_n` high, write with `wr_n` high, and a read. This separates a correct load from a load that ignores either qualifier. The mirrored pair 9990/9999 and writes at the window edges (1FFFh, 2000h, 3FFFh, 4000h) are checked on their own.

// File: rtl/mmio_mirror_pkg.sv
package mmio_mirror_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int TAG_W   = 3;
  localparam logic [TAG_W-1:0] WIN_TAG = 3'b001;
  localparam int NPORTS  = 2;
  localparam int SEL_W   = $clog2(NPORTS);

  typedef struct packed {
    logic [NPORTS-1:0] rd;
    logic [NPORTS-1:0] wr;
  } strobes_t;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_mirror_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int TW = TAG_W,
  parameter logic [TW-1:0] TAG = WIN_TAG,
  parameter int NP = NPORTS,
  parameter int SW = SEL_W
) (
  input  logic [AW-1:0] addr,
  input  logic          mreq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          in_win,
  output logic [SW-1:0] sel,
  output logic [NP-1:0] rd_stb,
  output logic [NP-1:0] wr_stb,
  output logic          rom_block
);
  localparam int GUARD_BIT = AW - TW;

  always_comb begin
    in_win    = (addr[AW-1 -: TW] == TAG);
    sel       = addr[SW-1:0];
    rom_block = addr[GUARD_BIT];
  end

  for (genvar p = 0; p < NP; p++) begin : g_stb
    always_comb begin
      rd_stb[p] = in_win && !mreq_n && !rd_n && (sel == SW'(p));
      wr_stb[p] = in_win && !mreq_n && !wr_n && (sel == SW'(p));
    end
  end
endmodule

// File: rtl/mmio_out_latch.sv
module mmio_out_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/mmio_read_mux.sv
module mmio_read_mux #(
  parameter int DW = 8,
  parameter int NP = 2
) (
  input  logic [NP-1:0][DW-1:0] src,
  input  logic [NP-1:0]         rd_stb,
  output logic [DW-1:0]         dout,
  output logic                  oe
);
  always_comb begin
    dout = '0;
    for (int p = 0; p < NP; p++)
      if (rd_stb[p]) dout = dout | src[p];
    oe = |rd_stb;
  end
endmodule

// File: rtl/mmio_mirror_ports.sv
module mmio_mirror_ports
  import mmio_mirror_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] port_in0,
  input  logic [DATA_W-1:0] port_in1,
  output logic [DATA_W-1:0] port_q0,
  output logic [DATA_W-1:0] port_q1,
  output logic              rom_cs_block
);
  logic              in_win;
  logic [SEL_W-1:0]  sel;
  strobes_t          stb;
  logic [NPORTS-1:0][DATA_W-1:0] q_bank;
  logic [NPORTS-1:0][DATA_W-1:0] in_bank;

  mmio_decode u_dec (
    .addr      (addr),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .in_win    (in_win),
    .sel       (sel),
    .rd_stb    (stb.rd),
    .wr_stb    (stb.wr),
    .rom_block (rom_cs_block)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_lat
    mmio_out_latch #(.DW(DATA_W)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (stb.wr[p]),
      .d     (din),
      .q     (q_bank[p])
    );
  end

  assign in_bank[0] = port_in0;
  assign in_bank[1] = port_in1;
  assign port_q0    = q_bank[0];
  assign port_q1    = q_bank[1];

  mmio_read_mux #(.DW(DATA_W), .NP(NPORTS)) u_mux (
    .src    (in_bank),
    .rd_stb (stb.rd),
    .dout   (dout),
    .oe     (dout_oe)
  );
endmodule

// File: rtl/mmio_mirror_chk.sv
module mmio_mirror_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [7:0]  din,
  input logic [7:0]  dout,
  input logic        dout_oe,
  input logic        mreq_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic [7:0]  port_in0,
  input logic [7:0]  port_in1,
  input logic [7:0]  port_q0,
  input logic [7:0]  port_q1,
  input logic        rom_cs_block
);
  logic win;
  assign win = (addr[15:13] == 3'b001);

  // R5
  wr0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !mreq_n && !wr_n && !addr[0]) |=> (port_q0 == $past(din)));
  // R5
  wr1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !mreq_n && !wr_n && addr[0]) |=> (port_q1 == $past(din)));
  // R6
  q0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win && !mreq_n && !wr_n && !addr[0]) |=> $stable(port_q0));
  // R6
  q1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win && !mreq_n && !wr_n && addr[0]) |=> $stable(port_q1));
  // R7
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (dout == (addr[0] ? port_in1 : port_in0)));
  // R2
  out_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> (!dout_oe && dout == 8'h00));
  // R8
  rom_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> rom_cs_block);
endmodule

bind mmio_mirror_ports mmio_mirror_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
  .dout_oe(dout_oe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
  .port_in0(port_in0), .port_in1(port_in1), .port_q0(port_q0),
  .port_q1(port_q1), .rom_cs_block(rom_cs_block)
);

// File: tb/sim_mmio_mirror_ports.sv
`timescale 1ns/100ps
module sim_mmio_mirror_ports;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0, port_in0 = '0, port_in1 = '0;
  logic mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] dout, port_q0, port_q1;
  logic dout_oe, rom_cs_block;

  int errors = 0, checks = 0;
  logic [7:0] m0 = 8'h00, m1 = 8'h00;

  always #2.5 clk = ~clk;

  mmio_mirror_ports u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .port_in0(port_in0), .port_in1(port_in1), .port_q0(port_q0),
    .port_q1(port_q1), .rom_cs_block(rom_cs_block)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  function automatic logic inwin(input logic [15:0] a);
    return a[15:13] == 3'b001;
  endfunction

  // one bus cycle: drive at negedge, edge, check latches at the next negedge
  task automatic bus_cyc(input logic [15:0] a, input logic [7:0] d,
                         input logic mq, input logic rd, input logic wr,
                         input string req);
    @(negedge clk);
    addr = a; din = d; mreq_n = mq; rd_n = rd; wr_n = wr;
    if (inwin(a) && !mq && !wr) begin
      if (a[0]) m1 = d; else m0 = d;
    end
    @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    chk(req, {24'h0, port_q0}, {24'h0, m0});
    chk(req, {24'h0, port_q1}, {24'h0, m1});
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {24'h0, port_q0}, 32'h0);
    chk("R1", {24'h0, port_q1}, 32'h0);
    rst_n = 1'b1;

    // R4 mirroring with decimal addresses 9990 (even) and 9999 (odd)
    bus_cyc(16'd9990, 8'hA5, 1'b0, 1'b1, 1'b0, "R4");
    chk("R4", {24'h0, port_q0}, 32'hA5);
    bus_cyc(16'd9999, 8'h3C, 1'b0, 1'b1, 1'b0, "R4");
    chk("R4", {24'h0, port_q1}, 32'h3C);
    chk("R3", {24'h0, port_q0}, 32'hA5);

    // R2 window edges: 1FFFh and 4000h ignored, 2000h and 3FFFh accepted
    bus_cyc(16'h1FFF, 8'h11, 1'b0, 1'b1, 1'b0, "R2");
    bus_cyc(16'h4000, 8'h22, 1'b0, 1'b1, 1'b0, "R2");
    bus_cyc(16'h2000, 8'h33, 1'b0, 1'b1, 1'b0, "R2");
    chk("R2", {24'h0, port_q0}, 32'h33);
    bus_cyc(16'h3FFF, 8'h44, 1'b0, 1'b1, 1'b0, "R2");
    chk("R2", {24'h0, port_q1}, 32'h44);

    // R5/R6 write sweep with rotating strobe mix
    for (int a = 0; a < 65536; a += 97) begin
      logic [7:0] d;
      d = 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
      case ((a / 97) % 4)
        0: bus_cyc(16'(a), d, 1'b0, 1'b1, 1'b0, "R5");
        1: bus_cyc(16'(a), d, 1'b1, 1'b1, 1'b0, "R6");
        2: bus_cyc(16'(a), d, 1'b0, 1'b1, 1'b1, "R6");
        default: bus_cyc(16'(a), d, 1'b0, 1'b0, 1'b1, "R6");
      endcase
    end

    // R7/R8/R3 read sweep over every address (combinational, wr_n high)
    @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] aa;
      logic [7:0] e;
      aa = 16'(a);
      addr = aa; mreq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
      port_in0 = aa[7:0] ^ 8'hC3;
      port_in1 = aa[15:8] ^ 8'h96;
      #0.5;
      e = inwin(aa) ? (aa[0] ? port_in1 : port_in0) : 8'h00;
      chk("R7", {23'h0, dout_oe, dout}, {23'h0, inwin(aa), e});
      chk("R8", {31'h0, rom_cs_block}, {31'h0, aa[13]});
      if (a % 256 == 0) begin
        mreq_n = 1'b1;
        #0.5;
        chk("R7", {23'h0, dout_oe, dout}, 32'h0);
        chk("R8", {31'h0, rom_cs_block}, {31'h0, aa[13]});
        mreq_n = 1'b0; rd_n = 1'b1;
        #0.5;
        chk("R7", {23'h0, dout_oe, dout}, 32'h0);
      end
    end
    mreq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    // R6: read sweep left latches untouched
    chk("R6", {24'h0, port_q0}, {24'h0, m0});
    chk("R6", {24'h0, port_q1}, {24'h0, m1});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule